// File: doc/BRIEF.md
# Battery Sleep-State Controller

This block decides when a battery monitor may drop from its active sampling state into a low-current sleep state, and when it must return. Once per averaged measurement it receives a battery current magnitude and a battery voltage, each with one valid strobe. In the active state it counts consecutive measurements whose current sits below an entry threshold, and it enters sleep once that count reaches a programmed length. In sleep it leaves on a single measurement whose current exceeds a separate exit threshold, or when a minute-based timer runs out.

While asleep, the block compares each voltage reading with the one before it. When two consecutive readings agree within a programmed tolerance, the block treats the voltage as a settled open-circuit value. It latches the later reading and raises a one-cycle interrupt. A second interrupt marks every change of state. All configuration arrives on static input ports as unsigned codes: current in 610 uA steps, voltage and tolerance in 195 uV steps, timeout in minutes.

Top module: `sleep_ctrl_top`

## Requirements
- R1: In the active state (`inSleep`=0), a valid sample with `ibatCode` strictly below `cfgEntryThr` advances a run counter. The sample that brings the run to the entry length moves the block to sleep. The entry length is `cfgEntryCount`, with 0 taken as 1 and values above 8 taken as 8.
- R2: In the active state, a valid sample with `ibatCode` equal to or above `cfgEntryThr` clears the run counter. Cycles without `sampleValid` leave it unchanged.
- R3: In sleep, a valid sample with `ibatCode` strictly above `cfgExitThr` returns the block to the active state. A sample equal to the exit threshold does not.
- R4: In sleep, `minuteTick` pulses are counted from zero at each entry. The tick that brings the count to the limit returns the block to the active state. The limit is `cfgTimeoutMin`, with values below 2 taken as 2 and values above 30 taken as 30. Ticks in the active state are ignored.
- R5: `inSleep` and `stateChgIrq` are registered. A transition decided by the inputs present at a clock edge shows on `inSleep` after that edge. `stateChgIrq` is high for exactly that one cycle.
- R6: In sleep, each valid sample that does not cause an exit becomes the reference for the next one. The first such sample after entry is only a reference. When a later sample differs from the reference by no more than `cfgOcvTol` (either sign), the block latches that sample's `vbatCode` on `ocvValue` and pulses `goodOcvIrq` for one cycle, both after the same edge.
- R7: At most one good open-circuit value is reported per stay in sleep. `ocvValue` changes only together with a `goodOcvIrq` pulse.
- R8: While `rstN` is low, `inSleep`, `stateChgIrq` and `goodOcvIrq` are 0, `ocvValue` is 0, and all counters and references are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Current and voltage sample present this cycle |
| ibatCode | input | 8 | Battery current magnitude, 610 uA per code |
| vbatCode | input | 16 | Battery voltage, 195 uV per code |
| minuteTick | input | 1 | One-cycle pulse per elapsed minute |
| cfgEntryCount | input | 4 | Consecutive low samples needed to enter sleep |
| cfgEntryThr | input | 8 | Sleep entry current threshold |
| cfgExitThr | input | 8 | Sleep exit current threshold |
| cfgTimeoutMin | input | 5 | Maximum minutes in sleep |
| cfgOcvTol | input | 6 | Voltage tolerance, 195 uV per code |
| inSleep | output | 1 | 1 while in the sleep state |
| stateChgIrq | output | 1 | One-cycle pulse on every state change |
| goodOcvIrq | output | 1 | One-cycle pulse when a settled voltage is found |
| ocvValue | output | 16 | Most recently latched settled voltage |

## Verification
A wrong run count or minute count does not show at the ports until the transition it governs. It then appears as an `inSleep` edge one or more samples or ticks early or late, together with a misplaced `stateChgIrq`. A stale voltage reference or a lost "already reported" flag shows only at the next valid sleep sample, as a missing, extra or wrong `goodOcvIrq`/`ocvValue` pair. The bench therefore compares every output against its reference model on every clock. It drives runs that reach the entry length exactly, runs that are broken at the threshold value, and readings at the tolerance edge in both directions, so that each off-by-one appears in the cycle where it occurs.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_SLEEP  = 1'b1
  } sleepState_t;

  // Strobes from the control to the voltage datapath
  typedef struct packed {
    logic clearRef;   // forget reference reading (sleep entry)
    logic takeRef;    // current reading becomes the reference
    logic latchOcv;   // capture current reading as settled voltage
  } dpStrobe_t;

endpackage

// File: rtl/sleep_ocv_path.sv
module sleep_ocv_path
  import sleep_ctrl_pkg::*;
#(
  parameter int CUR_W  = 8,
  parameter int VOLT_W = 16,
  parameter int TOL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CUR_W-1:0]  ibatCode,
  input  logic [VOLT_W-1:0] vbatCode,
  input  logic [CUR_W-1:0]  cfgEntryThr,
  input  logic [CUR_W-1:0]  cfgExitThr,
  input  logic [TOL_W-1:0]  cfgOcvTol,
  input  dpStrobe_t         strobe,
  output logic              belowEntry,
  output logic              aboveExit,
  output logic              deltaOk,
  output logic [VOLT_W-1:0] ocvValue
);

  localparam int PAD_W = VOLT_W - TOL_W;

  logic [VOLT_W-1:0] refVolt;
  logic              refValid;
  logic [VOLT_W-1:0] voltDelta;
  logic [VOLT_W-1:0] tolWide;

  assign belowEntry = (ibatCode < cfgEntryThr);
  assign aboveExit  = (ibatCode > cfgExitThr);

  assign tolWide   = {{PAD_W{1'b0}}, cfgOcvTol};
  assign voltDelta = (vbatCode >= refVolt) ? (vbatCode - refVolt)
                                           : (refVolt - vbatCode);
  assign deltaOk   = refValid && (voltDelta <= tolWide);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refVolt  <= '0;
      refValid <= 1'b0;
      ocvValue <= '0;
    end else begin
      if (strobe.clearRef) begin
        refValid <= 1'b0;
      end else if (strobe.takeRef) begin
        refVolt  <= vbatCode;
        refValid <= 1'b1;
      end
      if (strobe.latchOcv) begin
        ocvValue <= vbatCode;
      end
    end
  end

endmodule

// File: rtl/sleep_state_fsm.sv
module sleep_state_fsm
  import sleep_ctrl_pkg::*;
#(
  parameter int ENTRY_CFG_W = 4,
  parameter int ENTRY_MAX   = 8,
  parameter int TMO_CFG_W   = 5,
  parameter int TMO_MIN     = 2,
  parameter int TMO_MAX     = 30
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic                   minuteTick,
  input  logic                   belowEntry,
  input  logic                   aboveExit,
  input  logic                   deltaOk,
  input  logic [ENTRY_CFG_W-1:0] cfgEntryCount,
  input  logic [TMO_CFG_W-1:0]   cfgTimeoutMin,
  output dpStrobe_t              strobe,
  output logic                   inSleep,
  output logic                   stateChgIrq,
  output logic                   goodOcvIrq
);

  localparam logic [ENTRY_CFG_W-1:0] ENTRY_HI = ENTRY_CFG_W'(ENTRY_MAX);
  localparam logic [ENTRY_CFG_W-1:0] ENTRY_LO = ENTRY_CFG_W'(1);
  localparam logic [TMO_CFG_W-1:0]   TMO_HI   = TMO_CFG_W'(TMO_MAX);
  localparam logic [TMO_CFG_W-1:0]   TMO_LO   = TMO_CFG_W'(TMO_MIN);

  sleepState_t             state, stateNext;
  logic [ENTRY_CFG_W-1:0]  runCnt, runCntNext, runInc, entryLimit;
  logic [TMO_CFG_W-1:0]    minCnt, minCntNext, minInc, tmoLimit;
  logic                    ocvDone, ocvDoneNext;
  logic                    chgNext, ocvPulseNext, exitNow;

  // Clamp the programmed limits
  always_comb begin
    if (cfgEntryCount < ENTRY_LO)      entryLimit = ENTRY_LO;
    else if (cfgEntryCount > ENTRY_HI) entryLimit = ENTRY_HI;
    else                               entryLimit = cfgEntryCount;
    if (cfgTimeoutMin < TMO_LO)        tmoLimit = TMO_LO;
    else if (cfgTimeoutMin > TMO_HI)   tmoLimit = TMO_HI;
    else                               tmoLimit = cfgTimeoutMin;
  end

  assign runInc = runCnt + 1'b1;
  assign minInc = minCnt + 1'b1;

  always_comb begin
    stateNext    = state;
    runCntNext   = runCnt;
    minCntNext   = minCnt;
    ocvDoneNext  = ocvDone;
    chgNext      = 1'b0;
    ocvPulseNext = 1'b0;
    strobe       = '0;
    exitNow      = 1'b0;
    case (state)
      ST_ACTIVE: begin
        minCntNext = '0;
        if (sampleValid) begin
          if (belowEntry) begin
            if (runInc >= entryLimit) begin
              stateNext       = ST_SLEEP;
              runCntNext      = '0;
              chgNext         = 1'b1;
              ocvDoneNext     = 1'b0;
              strobe.clearRef = 1'b1;
            end else begin
              runCntNext = runInc;
            end
          end else begin
            runCntNext = '0;
          end
        end
      end
      default: begin
        runCntNext = '0;
        exitNow = (sampleValid && aboveExit) ||
                  (minuteTick && (minInc >= tmoLimit));
        if (exitNow) begin
          stateNext  = ST_ACTIVE;
          chgNext    = 1'b1;
          minCntNext = '0;
        end else begin
          if (minuteTick) minCntNext = minInc;
          if (sampleValid) begin
            strobe.takeRef = 1'b1;
            if (deltaOk && !ocvDone) begin
              strobe.latchOcv = 1'b1;
              ocvPulseNext    = 1'b1;
              ocvDoneNext     = 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_ACTIVE;
      runCnt      <= '0;
      minCnt      <= '0;
      ocvDone     <= 1'b0;
      stateChgIrq <= 1'b0;
      goodOcvIrq  <= 1'b0;
    end else begin
      state       <= stateNext;
      runCnt      <= runCntNext;
      minCnt      <= minCntNext;
      ocvDone     <= ocvDoneNext;
      stateChgIrq <= chgNext;
      goodOcvIrq  <= ocvPulseNext;
    end
  end

  assign inSleep = (state == ST_SLEEP);

endmodule

// File: rtl/sleep_ctrl_top.sv
module sleep_ctrl_top
  import sleep_ctrl_pkg::*;
#(
  parameter int CUR_W       = 8,
  parameter int VOLT_W      = 16,
  parameter int TOL_W       = 6,
  parameter int ENTRY_CFG_W = 4,
  parameter int ENTRY_MAX   = 8,
  parameter int TMO_CFG_W   = 5,
  parameter int TMO_MIN     = 2,
  parameter int TMO_MAX     = 30
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic [CUR_W-1:0]       ibatCode,
  input  logic [VOLT_W-1:0]      vbatCode,
  input  logic                   minuteTick,
  input  logic [ENTRY_CFG_W-1:0] cfgEntryCount,
  input  logic [CUR_W-1:0]       cfgEntryThr,
  input  logic [CUR_W-1:0]       cfgExitThr,
  input  logic [TMO_CFG_W-1:0]   cfgTimeoutMin,
  input  logic [TOL_W-1:0]       cfgOcvTol,
  output logic                   inSleep,
  output logic                   stateChgIrq,
  output logic                   goodOcvIrq,
  output logic [VOLT_W-1:0]      ocvValue
);

  dpStrobe_t dpStrobe;
  logic      belowEntry, aboveExit, deltaOk;

  sleep_ocv_path #(
    .CUR_W (CUR_W),
    .VOLT_W(VOLT_W),
    .TOL_W (TOL_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ibatCode   (ibatCode),
    .vbatCode   (vbatCode),
    .cfgEntryThr(cfgEntryThr),
    .cfgExitThr (cfgExitThr),
    .cfgOcvTol  (cfgOcvTol),
    .strobe     (dpStrobe),
    .belowEntry (belowEntry),
    .aboveExit  (aboveExit),
    .deltaOk    (deltaOk),
    .ocvValue   (ocvValue)
  );

  sleep_state_fsm #(
    .ENTRY_CFG_W(ENTRY_CFG_W),
    .ENTRY_MAX  (ENTRY_MAX),
    .TMO_CFG_W  (TMO_CFG_W),
    .TMO_MIN    (TMO_MIN),
    .TMO_MAX    (TMO_MAX)
  ) u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .minuteTick   (minuteTick),
    .belowEntry   (belowEntry),
    .aboveExit    (aboveExit),
    .deltaOk      (deltaOk),
    .cfgEntryCount(cfgEntryCount),
    .cfgTimeoutMin(cfgTimeoutMin),
    .strobe       (dpStrobe),
    .inSleep      (inSleep),
    .stateChgIrq  (stateChgIrq),
    .goodOcvIrq   (goodOcvIrq)
  );

endmodule

// File: rtl/sleep_ctrl_checker.sv
module sleep_ctrl_checker #(
  parameter int CUR_W     = 8,
  parameter int VOLT_W    = 16,
  parameter int TMO_CFG_W = 5,
  parameter int TMO_MIN   = 2,
  parameter int TMO_MAX   = 30
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleValid,
  input logic [CUR_W-1:0]     ibatCode,
  input logic                 minuteTick,
  input logic [CUR_W-1:0]     cfgEntryThr,
  input logic [CUR_W-1:0]     cfgExitThr,
  input logic [TMO_CFG_W-1:0] cfgTimeoutMin,
  input logic                 inSleep,
  input logic                 stateChgIrq,
  input logic                 goodOcvIrq,
  input logic [VOLT_W-1:0]    ocvValue
);

  logic [7:0] sleepMinutes;
  int         tmoLim;

  always_comb begin
    if (int'(cfgTimeoutMin) < TMO_MIN)      tmoLim = TMO_MIN;
    else if (int'(cfgTimeoutMin) > TMO_MAX) tmoLim = TMO_MAX;
    else                                    tmoLim = int'(cfgTimeoutMin);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sleepMinutes <= '0;
    else if (!inSleep)   sleepMinutes <= '0;
    else if (minuteTick) sleepMinutes <= sleepMinutes + 1'b1;
  end

  a_r1_entry_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSleep) |-> ($past(sampleValid) && ($past(ibatCode) < $past(cfgEntryThr))));

  a_r3_exit_on_high: assert property (@(posedge clk) disable iff (!rstN)
    (inSleep && sampleValid && (ibatCode > cfgExitThr)) |=> !inSleep);

  a_r4_timeout_bound: assert property (@(posedge clk) disable iff (!rstN)
    inSleep |-> (int'(sleepMinutes) < tmoLim));

  a_r5_pulse_marks_change: assert property (@(posedge clk) disable iff (!rstN)
    stateChgIrq |-> (inSleep != $past(inSleep)));

  a_r5_change_raises_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (inSleep != $past(inSleep)) |-> stateChgIrq);

  a_r6_ocv_in_sleep: assert property (@(posedge clk) disable iff (!rstN)
    goodOcvIrq |-> (inSleep && $past(sampleValid)));

  a_r7_value_held: assert property (@(posedge clk) disable iff (!rstN)
    !goodOcvIrq |-> $stable(ocvValue));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    goodOcvIrq |=> !goodOcvIrq);

endmodule

bind sleep_ctrl_top sleep_ctrl_checker #(
  .CUR_W    (CUR_W),
  .VOLT_W   (VOLT_W),
  .TMO_CFG_W(TMO_CFG_W),
  .TMO_MIN  (TMO_MIN),
  .TMO_MAX  (TMO_MAX)
) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .sampleValid  (sampleValid),
  .ibatCode     (ibatCode),
  .minuteTick   (minuteTick),
  .cfgEntryThr  (cfgEntryThr),
  .cfgExitThr   (cfgExitThr),
  .cfgTimeoutMin(cfgTimeoutMin),
  .inSleep      (inSleep),
  .stateChgIrq  (stateChgIrq),
  .goodOcvIrq   (goodOcvIrq),
  .ocvValue     (ocvValue)
);

// File: tb/sleep_ctrl_top_tb.sv
`timescale 1ns/1ps
module sleep_ctrl_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [7:0]  ibatCode = '0;
  logic [15:0] vbatCode = '0;
  logic        minuteTick = 1'b0;
  logic [3:0]  cfgEntryCount = 4'd3;
  logic [7:0]  cfgEntryThr = 8'd50;
  logic [7:0]  cfgExitThr = 8'd80;
  logic [4:0]  cfgTimeoutMin = 5'd3;
  logic [5:0]  cfgOcvTol = 6'd4;
  logic        inSleep, stateChgIrq, goodOcvIrq;
  logic [15:0] ocvValue;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int mSleep = 0, mChg = 0, mGood = 0, mOcv = 0;
  int mRun = 0, mMin = 0, mRef = 0, mHaveRef = 0, mDone = 0;

  always #2 clk = ~clk;

  sleep_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .ibatCode(ibatCode),
    .vbatCode(vbatCode), .minuteTick(minuteTick), .cfgEntryCount(cfgEntryCount),
    .cfgEntryThr(cfgEntryThr), .cfgExitThr(cfgExitThr), .cfgTimeoutMin(cfgTimeoutMin),
    .cfgOcvTol(cfgOcvTol), .inSleep(inSleep), .stateChgIrq(stateChgIrq),
    .goodOcvIrq(goodOcvIrq), .ocvValue(ocvValue)
  );

  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSleep = 0; mChg = 0; mGood = 0; mOcv = 0;
      mRun = 0; mMin = 0; mRef = 0; mHaveRef = 0; mDone = 0;
    end else begin
      int nEnt, lim, ib, vb, dlt;
      nEnt = clampI(int'(cfgEntryCount), 1, 8);
      lim  = clampI(int'(cfgTimeoutMin), 2, 30);
      ib = int'(ibatCode);
      vb = int'(vbatCode);
      mChg = 0; mGood = 0;
      if (mSleep == 0) begin
        if (sampleValid) begin
          if (ib < int'(cfgEntryThr)) begin
            mRun++;
            if (mRun >= nEnt) begin
              mSleep = 1; mChg = 1; mRun = 0; mMin = 0; mHaveRef = 0; mDone = 0;
            end
          end else mRun = 0;
        end
      end else if ((sampleValid && ib > int'(cfgExitThr)) || (minuteTick && mMin + 1 >= lim)) begin
        mSleep = 0; mChg = 1; mMin = 0; mRun = 0;
      end else begin
        if (minuteTick) mMin++;
        if (sampleValid) begin
          dlt = (vb > mRef) ? vb - mRef : mRef - vb;
          if (mHaveRef && dlt <= int'(cfgOcvTol) && !mDone) begin
            mOcv = vb; mGood = 1; mDone = 1;
          end
          mRef = vb; mHaveRef = 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1 R2 R3 R4 inSleep", int'(inSleep), mSleep);
      chk("R5 stateChgIrq", int'(stateChgIrq), mChg);
      chk("R6 R7 goodOcvIrq", int'(goodOcvIrq), mGood);
      chk("R6 R7 ocvValue", int'(ocvValue), mOcv);
    end
  end

  task automatic step(bit sv, int ib, int vb, bit tk);
    @(negedge clk);
    sampleValid = sv; ibatCode = 8'(ib); vbatCode = 16'(vb); minuteTick = tk;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset inSleep", int'(inSleep), 0);
    chk("R8 reset stateChgIrq", int'(stateChgIrq), 0);
    chk("R8 reset goodOcvIrq", int'(goodOcvIrq), 0);
    chk("R8 reset ocvValue", int'(ocvValue), 0);
    rstN = 1'b1;
    idle(2);
    // R2 run broken by gap-free high sample at threshold value, R1 entry on third
    step(1, 10, 900, 0); step(1, 20, 900, 0); step(0, 0, 0, 1);
    step(1, 50, 900, 0); step(1, 10, 900, 0); step(1, 10, 900, 0);
    step(1, 49, 900, 0); idle(2);
    // R6 reference, too wide, within tolerance (negative), R7 no second report
    step(1, 80, 1000, 0); step(1, 5, 1010, 0); step(1, 5, 1007, 0);
    step(1, 5, 1007, 0); idle(1);
    // R3 exit just above threshold
    step(1, 81, 1007, 0); idle(2);
    // re-enter, R6 delta equal to tolerance, R4 timeout after 3 ticks
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    step(1, 5, 2000, 0); step(1, 5, 2004, 0);
    step(0, 0, 0, 1); idle(2); step(0, 0, 0, 1); step(0, 0, 0, 1); idle(2);
    // R4 clamp low: 0 -> 2 ticks
    cfgTimeoutMin = 5'd0;
    step(0, 0, 0, 1);
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    step(0, 0, 0, 1); step(0, 0, 0, 1); idle(2);
    // R4 clamp high: 31 -> 30 ticks
    cfgTimeoutMin = 5'd31;
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    for (int i = 0; i < 31; i++) step(0, 0, 0, 1);
    idle(2);
    // R1 entry length clamps: 0 -> 1, 15 -> 8
    cfgTimeoutMin = 5'd3;
    cfgEntryCount = 4'd0;
    step(1, 1, 0, 0); idle(1); step(1, 200, 0, 0); idle(2);
    cfgEntryCount = 4'd15;
    for (int i = 0; i < 9; i++) step(1, 2, 0, 0);
    step(1, 200, 0, 0); idle(2);
    // mixed stimulus
    cfgEntryCount = 4'd2; cfgEntryThr = 8'd100; cfgExitThr = 8'd150; cfgOcvTol = 6'd6;
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[9] | lfsr[10], lfsr[8] ? int'(lfsr[5:0]) : int'(lfsr[7:0]),
           2000 + int'(lfsr[3:0]), lfsr[15:12] == 4'd0);
    end
    // R8 reset mid-operation
    idle(2);
    rstN = 1'b0;
    @(negedge clk);
    chk("R8 reset again inSleep", int'(inSleep), 0);
    chk("R8 reset again ocvValue", int'(ocvValue), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule